// File: doc/BRIEF.md
# Socket Status-Change Event Register

This block watches four socket status lines and keeps a sticky record that each one has changed. The lines are a power-cycle flag, two card-detect lines and a card status-change line. Each record bit says only that a change happened. Software reads the live levels elsewhere, reads this 32-bit register to learn which lines moved, and then writes ones to acknowledge them. A separate force port lets software set any event bit to test its handlers. A registered interrupt is raised while any recorded event is enabled by the mask input.

All status inputs, and the card-reset indication, cross into the clock domain through a two-stage synchronizer. Each synchronized line is then compared with its value from the previous cycle. The card-type input decides how the status-change line is treated. A 32-bit card records only rising transitions. A 16-bit card records both directions.

There are two synchronous active-low resets. The global reset clears everything. The bus reset clears the three upper event bits, and clears the status-change bit only when power management is off. When the card leaves its reset state, the status-change bit and the card-detect bits are set again if their lines are still asserted.

Top module: `sockEventReg`

## Requirements
- R1: Read bits 31 down to 4 are always 0, and the upper bits of a clear write or a force write change nothing.
- R2: A change in either direction on statusIn[3] (power cycle), statusIn[2] (card detect 2) or statusIn[1] (card detect 1) sets rdData bit 3, 2 or 1 respectively. The bit is visible on the third rising edge after the input change and not before.
- R3: The status-change line statusIn[0] sets rdData bit 0 on a rising transition only when cardType=1 (32-bit card), and on both transitions when cardType=0 (16-bit card).
- R4: When wrEn is high, a 1 in wrData bit i clears event bit i at the next edge, and a 0 leaves it unchanged.
- R5: When forceEn is high, a 1 in forceData bit i sets event bit i at the next edge.
- R6: irq is a register that equals the OR of (event bits AND intMask) as sampled at the previous rising edge.
- R7: If a hardware event and a clear write reach the same bit at the same edge, the bit ends up set.
- R8: While globalRstN is low, every event bit and irq are cleared, so the register reads 0000_0000h.
- R9: While busRstN is low, bits 3 to 1 are cleared. Bit 0 is also cleared if pmEnable=0, and it keeps its value if pmEnable=1.
- R10: On a falling transition of cardReset, bit 0 is set if statusIn[0] is high, bit 1 if statusIn[1] is high, and bit 2 if statusIn[2] is high. This happens on the third edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| globalRstN | input | 1 | Global synchronous reset, active low, clears all state |
| busRstN | input | 1 | Bus synchronous reset, active low, clears bits 3..1, and bit 0 when pmEnable is 0 |
| pmEnable | input | 1 | Power-management enable; shields bit 0 from the bus reset |
| cardType | input | 1 | 1 = 32-bit card (rising edge only), 0 = 16-bit card (both edges) |
| cardReset | input | 1 | Card held in reset; a falling transition re-arms events |
| statusIn | input | 4 | [3] power cycle, [2] card detect 2, [1] card detect 1, [0] status change |
| wrEn | input | 1 | Clear-write strobe |
| wrData | input | 32 | Clear-write data, one per bit clears |
| forceEn | input | 1 | Force-write strobe |
| forceData | input | 32 | Force-write data, one per bit sets |
| intMask | input | 4 | Per-event interrupt enable |
| rdData | output | 32 | Register read value |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong edge-detector history shows up as a spurious or missing event bit on rdData three edges after the input moves. An interrupt that disagrees with the read value appears one edge after that. A clear or force that reaches the wrong bit, or a reset that spares the wrong bit, is visible on rdData on the edge that follows the write or the reset. The bench therefore reads the register after every stimulus. It also checks the exact edge on which an event first appears, so that a lost or extra pipeline stage is caught.

// File: rtl/sockEvtPkg.sv
package sockEvtPkg;

  localparam int NUM_EVT  = 4;
  localparam int EVT_CSTS = 0;
  localparam int EVT_CD1  = 1;
  localparam int EVT_CD2  = 2;
  localparam int EVT_PWR  = 3;

  // Per-bit strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic [NUM_EVT-1:0] hwSet;  // hardware change detected
    logic [NUM_EVT-1:0] swSet;  // software force
    logic [NUM_EVT-1:0] swClr;  // software write-one-to-clear
    logic [NUM_EVT-1:0] rstClr; // reset applies to this bit
  } evtStrobes_t;

endpackage

// File: rtl/sockEvtSync.sv
module sockEvtSync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) pipe[s] <= pipe[s-1];
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/sockEvtCtrl.sv
module sockEvtCtrl
  import sockEvtPkg::*;
(
  input  logic               clk,
  input  logic               globalRstN,
  input  logic               busRstN,
  input  logic               pmEnable,
  input  logic               cardType,
  input  logic [NUM_EVT-1:0] statusSync,
  input  logic               cardRstSync,
  input  logic               wrEn,
  input  logic [NUM_EVT-1:0] wrBits,
  input  logic               forceEn,
  input  logic [NUM_EVT-1:0] forceBits,
  output evtStrobes_t        strb
);

  // History registers track the synchronized lines continuously, so no
  // spurious edge appears when a reset is released.
  logic [NUM_EVT-1:0] statusPrev;
  logic               cardRstPrev;

  always_ff @(posedge clk) begin
    statusPrev  <= statusSync;
    cardRstPrev <= cardRstSync;
  end

  logic [NUM_EVT-1:0] anyEdge;
  logic [NUM_EVT-1:0] riseEdge;
  logic               leaveCardRst;
  logic               busHit;
  logic               globalHit;

  assign anyEdge      = statusSync ^ statusPrev;
  assign riseEdge     = statusSync & ~statusPrev;
  assign leaveCardRst = cardRstPrev & ~cardRstSync;
  assign busHit       = ~busRstN;
  assign globalHit    = ~globalRstN;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    if (i == EVT_CSTS) begin : g_csts
      // 32-bit card: rising only; 16-bit card: either direction.
      assign strb.hwSet[i]  = (cardType ? riseEdge[i] : anyEdge[i]) |
                              (leaveCardRst & statusSync[i]);
      // Power-management enable shields this bit from the bus reset.
      assign strb.rstClr[i] = globalHit | (busHit & ~pmEnable);
    end else if (i == EVT_CD1 || i == EVT_CD2) begin : g_detect
      assign strb.hwSet[i]  = anyEdge[i] | (leaveCardRst & statusSync[i]);
      assign strb.rstClr[i] = globalHit | busHit;
    end else begin : g_plain
      assign strb.hwSet[i]  = anyEdge[i];
      assign strb.rstClr[i] = globalHit | busHit;
    end
    assign strb.swSet[i] = forceEn & forceBits[i];
    assign strb.swClr[i] = wrEn & wrBits[i];
  end

endmodule

// File: rtl/sockEvtDatapath.sv
module sockEvtDatapath
  import sockEvtPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               globalRstN,
  input  evtStrobes_t        strb,
  input  logic [NUM_EVT-1:0] intMask,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] evt;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (strb.rstClr[i]) evt[i] <= 1'b0;
      else                evt[i] <= (evt[i] & ~strb.swClr[i]) |
                                    strb.hwSet[i] | strb.swSet[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!globalRstN) irq <= 1'b0;
    else             irq <= |(evt & intMask);
  end

  assign rdData = {{PAD_W{1'b0}}, evt};

endmodule

// File: rtl/sockEventReg.sv
module sockEventReg
  import sockEvtPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               globalRstN,
  input  logic               busRstN,
  input  logic               pmEnable,
  input  logic               cardType,
  input  logic               cardReset,
  input  logic [NUM_EVT-1:0] statusIn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               forceEn,
  input  logic [DATA_W-1:0]  forceData,
  input  logic [NUM_EVT-1:0] intMask,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  localparam int SYNC_W = NUM_EVT + 1;

  logic [SYNC_W-1:0] syncOut;
  evtStrobes_t       strb;
  logic              unusedHiBits;

  // Reserved positions of the write ports carry no function.
  assign unusedHiBits = ^{wrData[DATA_W-1:NUM_EVT], forceData[DATA_W-1:NUM_EVT]};

  sockEvtSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .din  ({cardReset, statusIn}),
    .dout (syncOut)
  );

  sockEvtCtrl uCtrl (
    .clk         (clk),
    .globalRstN  (globalRstN),
    .busRstN     (busRstN),
    .pmEnable    (pmEnable),
    .cardType    (cardType),
    .statusSync  (syncOut[NUM_EVT-1:0]),
    .cardRstSync (syncOut[NUM_EVT]),
    .wrEn        (wrEn),
    .wrBits      (wrData[NUM_EVT-1:0]),
    .forceEn     (forceEn),
    .forceBits   (forceData[NUM_EVT-1:0]),
    .strb        (strb)
  );

  sockEvtDatapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .globalRstN (globalRstN),
    .strb       (strb),
    .intMask    (intMask),
    .rdData     (rdData),
    .irq        (irq)
  );

endmodule

// File: rtl/sockEvtChk.sv
module sockEvtChk
  import sockEvtPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               globalRstN,
  input logic               busRstN,
  input logic               pmEnable,
  input logic [NUM_EVT-1:0] intMask,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq,
  input evtStrobes_t        strb
);

  logic [NUM_EVT-1:0] evtRd;
  assign evtRd = rdData[NUM_EVT-1:0];

  always_comb begin
    if (globalRstN) AST_RSVD_ZERO: assert (rdData[DATA_W-1:NUM_EVT] == '0); // R1
  end

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!globalRstN)
    (strb.swClr & ~strb.hwSet & ~strb.swSet) != '0 |=>
      (evtRd & $past(strb.swClr & ~strb.hwSet & ~strb.swSet)) == '0); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!globalRstN)
    (busRstN && ((strb.hwSet | strb.swSet) != '0)) |=>
      (evtRd & $past(strb.hwSet | strb.swSet)) == $past(strb.hwSet | strb.swSet)); // R7

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!globalRstN)
    1'b1 |=> irq == $past(|(evtRd & intMask))); // R6

  AST_BUSRST_UPPER: assert property (@(posedge clk) disable iff (!globalRstN)
    !busRstN |=> evtRd[NUM_EVT-1:1] == '0); // R9

  AST_PM_HOLD: assert property (@(posedge clk) disable iff (!globalRstN)
    (!busRstN && pmEnable && evtRd[EVT_CSTS] && !strb.swClr[EVT_CSTS]) |=>
      evtRd[EVT_CSTS]); // R9

  AST_GLOBAL_CLEAR: assert property (@(posedge clk)
    !globalRstN |=> (rdData == '0 && !irq)); // R8

endmodule

bind sockEventReg sockEvtChk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .globalRstN (globalRstN),
  .busRstN    (busRstN),
  .pmEnable   (pmEnable),
  .intMask    (intMask),
  .rdData     (rdData),
  .irq        (irq),
  .strb       (strb)
);

// File: tb/tb_sockEventReg.sv
module tb_sockEventReg;

  logic        clk = 1'b0;
  logic        globalRstN, busRstN, pmEnable, cardType, cardReset;
  logic [3:0]  statusIn, intMask;
  logic        wrEn, forceEn;
  logic [31:0] wrData, forceData, rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [3:0] mdl;

  always #2 clk = ~clk;

  sockEventReg dut (
    .clk(clk), .globalRstN(globalRstN), .busRstN(busRstN), .pmEnable(pmEnable),
    .cardType(cardType), .cardReset(cardReset), .statusIn(statusIn),
    .wrEn(wrEn), .wrData(wrData), .forceEn(forceEn), .forceData(forceData),
    .intMask(intMask), .rdData(rdData), .irq(irq)
  );

  function automatic logic expIrq(input logic [3:0] e, input logic [3:0] m);
    return |(e & m);
  endfunction

  function automatic logic [3:0] afterToggle(input logic [3:0] e, input int idx,
                                             input logic newLvl, input logic ct);
    logic [3:0] r = e;
    if (idx != 0 || !ct || newLvl) r[idx] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clearWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d; cyc(1); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic forceWrite(input logic [31:0] d);
    forceEn = 1'b1; forceData = d; cyc(1); forceEn = 1'b0; forceData = '0;
  endtask

  task automatic checkAll(input string tag);
    check({tag, " rd"}, rdData, {28'b0, mdl});
    check({tag, " irq"}, {31'b0, irq}, {31'b0, expIrq(mdl, intMask)});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c3a));
    globalRstN = 0; busRstN = 1; pmEnable = 0; cardType = 1; cardReset = 0;
    statusIn = 0; intMask = 4'hF; wrEn = 0; wrData = 0; forceEn = 0; forceData = 0;
    @(negedge clk);
    cyc(6);
    mdl = 0;
    checkAll("R8 reset state");
    globalRstN = 1;
    cyc(2);
    checkAll("R8 after release");

    // R2 exact latency: bit 2 appears on third edge, irq one edge later.
    intMask = 4'b0100;
    statusIn[2] = 1'b1;
    cyc(2);
    check("R2 not before third edge", rdData, 32'h0);
    cyc(1);
    check("R2 third edge", rdData, 32'h4);
    check("R6 irq lags", {31'b0, irq}, 32'h0);
    cyc(1);
    check("R6 irq asserted", {31'b0, irq}, 32'h1);
    mdl = 4'h4;
    intMask = 4'b1011;
    cyc(2);
    checkAll("R6 masked off");

    // R4 clear one bit; zeros leave others.
    forceWrite(32'h0000_000B);
    mdl = 4'hF;
    check("R5 force sets", rdData, 32'hF);
    clearWrite(32'h0000_0002);
    mdl = 4'hD;
    check("R4 selective clear", rdData, 32'hD);
    // R1 upper bits of both ports inert.
    forceWrite(32'hFFFF_FFF0);
    clearWrite(32'hFFFF_FFF0);
    check("R1 reserved inert", rdData, 32'hD);
    clearWrite(32'hF);
    mdl = 0;
    cyc(1);
    checkAll("R4 clear all");

    // R7 set wins: write lands on the edge that records a change.
    statusIn[1] = 1'b1;
    cyc(2);
    wrEn = 1'b1; wrData = 32'h2; cyc(1); wrEn = 1'b0; wrData = 0;
    check("R7 set wins", rdData, 32'h2);
    clearWrite(32'h2);
    check("R4 clear after", rdData, 32'h0);

    // R3 32-bit card: falling edge ignored, rising recorded.
    cardType = 1;
    statusIn[0] = 1'b1; cyc(5);
    check("R3 rising 32-bit", rdData, 32'h1);
    clearWrite(32'h1);
    statusIn[0] = 1'b0; cyc(5);
    check("R3 falling 32-bit ignored", rdData, 32'h0);
    cardType = 0;
    statusIn[0] = 1'b1; cyc(5);
    check("R3 rising 16-bit", rdData, 32'h1);
    clearWrite(32'h1);
    statusIn[0] = 1'b0; cyc(5);
    check("R3 falling 16-bit", rdData, 32'h1);

    // R9 bus reset with and without power management.
    forceWrite(32'hF);
    pmEnable = 1; busRstN = 0; cyc(2); busRstN = 1;
    check("R9 pm keeps bit0", rdData, 32'h1);
    forceWrite(32'hF);
    pmEnable = 0; busRstN = 0; cyc(2); busRstN = 1;
    check("R9 bus clears all", rdData, 32'h0);

    // R10 re-arm on leaving card reset.
    cardType = 1;
    cardReset = 1; cyc(4);
    statusIn = 4'b0011; cyc(5);
    clearWrite(32'hF);
    check("R10 cleared before release", rdData, 32'h0);
    cardReset = 0;
    cyc(2);
    check("R10 not yet", rdData, 32'h0);
    cyc(1);
    check("R10 re-arm", rdData, 32'h3);
    statusIn = 0; cyc(5);
    clearWrite(32'hF);
    mdl = 0;

    // R8 global reset mid-run.
    forceWrite(32'hF);
    globalRstN = 0; cyc(2); globalRstN = 1; cyc(1);
    checkAll("R8 global clears");

    // Constrained random mix of toggles, forces, clears and mask changes.
    for (int it = 0; it < 200; it++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0, 1: begin
          int idx = $urandom_range(0, 3);
          logic nl = ~statusIn[idx];
          mdl = afterToggle(mdl, idx, nl, cardType);
          statusIn[idx] = nl;
          cyc(5);
          checkAll("R2 R3 random toggle");
        end
        2: begin
          logic [31:0] d = $urandom;
          mdl = mdl | d[3:0];
          forceWrite(d); cyc(1);
          checkAll("R5 random force");
        end
        3: begin
          logic [31:0] d = $urandom;
          mdl = mdl & ~d[3:0];
          clearWrite(d); cyc(1);
          checkAll("R4 random clear");
        end
        default: begin
          intMask = 4'($urandom);
          cardType = 1'($urandom);
          cyc(2);
          checkAll("R6 random mask");
        end
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule